// File: doc/BRIEF.md
# Precharged Key Matrix Scanner

This block scans a key matrix of `NCOL` column drive lines and `NROW` row sense lines without any software help. Every scan visits the columns in order, 0 first. Before each column it drives all columns inactive and holds a precharge strobe high for one settle interval. It then drives that single column for a second settle interval and captures the row lines at the end of that interval. After the last column it holds all columns inactive and issues one more precharge pulse. Only then does the scan count as complete.

Each key position has a number, `row + column * NROW`, and keeps two stored bits: the state captured by the newest scan and the state last reported. Once the scan is complete, the block walks every key number from 0 upwards. Each key whose two bits differ produces one event on a valid/ready port, carrying the key number and its new state. The walk stops on a pending event until the consumer accepts it. A new scan starts once per scan period. Both the settle interval and the scan period are derived from a clock-frequency parameter.

The controller is a five-state machine. IDLE waits for the enable and the period timer. CHARGE drives the precharge strobe. SELECT drives one column. TAIL is the closing precharge pulse. EMIT walks the key numbers. The transitions are:
- IDLE→CHARGE on a scan start.
- CHARGE→SELECT when the settle interval ends.
- SELECT→CHARGE when the settle interval ends and more columns remain.
- SELECT→TAIL when the settle interval ends on the last column.
- TAIL→EMIT when the settle interval ends.
- EMIT→IDLE after the last key number.
- Any state→IDLE when the enable is low.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: After reset all column outputs, `charge`, `evt_valid` and `keydown` are 0, and every stored key bit reads released, so a first scan with no key down produces no event.
- R2: Each column drive is preceded by exactly S cycles with all columns 0 and `charge` 1, where S is the settle length of R12.
- R3: Column n is driven as bit n of the strobe, alone. Bits 7..0 go out on `col_lo` and bits NCOL-1..8 on `col_hi`. The strobe is held for S cycles with `charge` 0.
- R4: A row line captured during the last cycle of column c's drive window sets the state of key number `r + c*NROW` from row bit r (1 = pressed).
- R5: After the last column window, all columns are 0 and `charge` is 1 for S cycles before any event appears.
- R6: After a scan, each key whose captured state differs from its reported state yields one event, with `evt_index` the key number and `evt_state` the new state (1 press, 0 release). The reported state is updated when the event is accepted. Unchanged keys yield nothing.
- R7: Events within a scan appear in strictly ascending key number order, one key number examined per cycle.
- R8: While `evt_valid` is 1 and `evt_ready` is 0, the event is held with unchanged index and state and no change is dropped.
- R9: Scan starts are spaced by the period P, counted from start to start. A scan that ends later than P after its start is followed at once by the next one.
- R10: With `enable` low the block starts no scan and emits nothing. Dropping `enable` mid-scan returns it to IDLE on the next cycle with all outputs quiet, and unreported changes are reported by a later scan.
- R11: `keydown` clears at each scan start and sets when an accepted event in that scan is a press.
- R12: S = CLK_HZ*SETTLE_NS/10^9 and P = CLK_HZ*PERIOD_NS/10^9 clock cycles, each at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Scan enable |
| col_lo | output | 8 | Column strobe bits 7..0 |
| col_hi | output | NCOL-8 | Column strobe bits NCOL-1..8 |
| charge | output | 1 | Precharge strobe |
| row_in | input | NROW | Row sense lines, 1 = key closed |
| evt_valid | output | 1 | Event present |
| evt_ready | input | 1 | Consumer accepts event |
| evt_index | output | clog2(NCOL*NROW) | Key number of the event |
| evt_state | output | 1 | New state, 1 = pressed |
| keydown | output | 1 | A press was reported in the current scan |

## Verification
The bench targets these corner cases:
- The boundary keys 0, 41 (row 6) and 83. An off-by-one in the index formula or the column walk would misname these keys or miss them.
- Consumer stalls. A walker that advances without the handshake would drop or repeat events.
- A scan with only releases. A `keydown` flag that tracks any event instead of presses would set on it.
- A disable in the middle of a scan. A design that finished the scan anyway would keep driving the columns. A design that committed the captured states too early would lose the press for good.
- The timing edges themselves, compared every cycle against a behavioural time model. A miscounted settle or period counter shows up there as a shifted or wider strobe.

// File: rtl/kms_pkg.sv
package kms_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHARGE,
        ST_SELECT,
        ST_TAIL,
        ST_EMIT
    } kms_state_e;

    function automatic int unsigned kms_cycles(input int unsigned hz, input int unsigned ns);
        longint unsigned raw;
        raw = (longint'(hz) * longint'(ns)) / 64'd1_000_000_000;
        return (raw < 1) ? 1 : int'(raw);
    endfunction
endpackage

// File: rtl/kms_interval_timer.sv
module kms_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/kms_key_store.sv
module kms_key_store #(
    parameter int NCOL = 12,
    parameter int NROW = 7,
    parameter int CW   = 4,
    parameter int IW   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_en,
    input  logic [CW-1:0]   sample_col,
    input  logic [NROW-1:0] row_in,
    input  logic            commit_en,
    input  logic [IW-1:0]   look_idx,
    output logic            cur_bit,
    output logic            prev_bit
);
    localparam int NKEY = NCOL * NROW;

    logic [NKEY-1:0] cur_q;
    logic [NKEY-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            for (int k = 0; k < NKEY; k++) begin
                if (sample_en && sample_col == CW'(k / NROW))
                    cur_q[k] <= row_in[k % NROW];
                if (commit_en && look_idx == IW'(k))
                    prev_q[k] <= cur_q[k];
            end
        end
    end

    assign cur_bit  = cur_q[look_idx];
    assign prev_bit = prev_q[look_idx];
endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner
    import kms_pkg::*;
#(
    parameter int NCOL      = 12,
    parameter int NROW      = 7,
    parameter int CLK_HZ    = 200_000_000,
    parameter int SETTLE_NS = 20_000,
    parameter int PERIOD_NS = 50_000_000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            enable,
    output logic [7:0]                      col_lo,
    output logic [NCOL-9:0]                 col_hi,
    output logic                            charge,
    input  logic [NROW-1:0]                 row_in,
    output logic                            evt_valid,
    input  logic                            evt_ready,
    output logic [$clog2(NCOL*NROW)-1:0]    evt_index,
    output logic                            evt_state,
    output logic                            keydown
);
    localparam int NKEY       = NCOL * NROW;
    localparam int CW         = $clog2(NCOL);
    localparam int IW         = $clog2(NKEY);
    localparam int SETTLE_CYC = kms_cycles(CLK_HZ, SETTLE_NS);
    localparam int PERIOD_CYC = kms_cycles(CLK_HZ, PERIOD_NS);
    localparam int SW         = $clog2(SETTLE_CYC + 1);
    localparam int PW         = $clog2(PERIOD_CYC + 1);

    kms_state_e    state_q, state_d;
    logic [CW-1:0] col_q;
    logic [IW-1:0] idx_q;
    logic          keydown_q;
    logic [NCOL-1:0] col_vec;

    logic settle_done, period_done, settle_load;
    logic start, last_col, last_key, changed;
    logic in_emit, step, commit, sample_en;
    logic cur_bit, prev_bit;

    // timers: one for each settle window, one for start-to-start spacing
    kms_interval_timer #(.W(SW)) u_settle (
        .clk(clk), .rst_n(rst_n), .load(settle_load),
        .load_val(SW'(SETTLE_CYC - 1)), .expired(settle_done)
    );

    kms_interval_timer #(.W(PW)) u_period (
        .clk(clk), .rst_n(rst_n), .load(start),
        .load_val(PW'(PERIOD_CYC - 1)), .expired(period_done)
    );

    kms_key_store #(.NCOL(NCOL), .NROW(NROW), .CW(CW), .IW(IW)) u_keys (
        .clk(clk), .rst_n(rst_n),
        .sample_en(sample_en), .sample_col(col_q), .row_in(row_in),
        .commit_en(commit), .look_idx(idx_q),
        .cur_bit(cur_bit), .prev_bit(prev_bit)
    );

    assign start     = (state_q == ST_IDLE) && enable && period_done;
    assign last_col  = (col_q == CW'(NCOL - 1));
    assign last_key  = (idx_q == IW'(NKEY - 1));
    assign changed   = cur_bit ^ prev_bit;
    assign in_emit   = (state_q == ST_EMIT) && enable;
    assign step      = in_emit && (!changed || evt_ready);
    assign commit    = in_emit && changed && evt_ready;
    assign sample_en = (state_q == ST_SELECT) && enable && settle_done;
    assign settle_load = (state_d != state_q) &&
                         (state_d == ST_CHARGE || state_d == ST_SELECT || state_d == ST_TAIL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CHARGE;
            ST_CHARGE: begin
                if (!enable)          state_d = ST_IDLE;
                else if (settle_done) state_d = ST_SELECT;
            end
            ST_SELECT: begin
                if (!enable)          state_d = ST_IDLE;
                else if (settle_done) state_d = last_col ? ST_TAIL : ST_CHARGE;
            end
            ST_TAIL: begin
                if (!enable)          state_d = ST_IDLE;
                else if (settle_done) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (!enable)              state_d = ST_IDLE;
                else if (step && last_key) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // column, key-walk and press-flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q     <= '0;
            idx_q     <= '0;
            keydown_q <= 1'b0;
        end else begin
            if (start) begin
                col_q     <= '0;
                keydown_q <= 1'b0;
            end else if (sample_en && !last_col) begin
                col_q <= col_q + 1'b1;
            end
            if (state_q == ST_TAIL && enable && settle_done)
                idx_q <= '0;
            else if (step && !last_key)
                idx_q <= idx_q + 1'b1;
            if (commit && cur_bit)
                keydown_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        col_vec   = '0;
        charge    = 1'b0;
        evt_valid = 1'b0;
        unique case (state_q)
            ST_CHARGE: charge = 1'b1;
            ST_SELECT: col_vec = NCOL'(1) << col_q;
            ST_TAIL:   charge = 1'b1;
            ST_EMIT:   evt_valid = changed;
            default: ;
        endcase
    end

    assign col_lo    = col_vec[7:0];
    assign col_hi    = col_vec[NCOL-1:8];
    assign evt_index = idx_q;
    assign evt_state = cur_bit;
    assign keydown   = keydown_q;

    // R2
    precharge_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|{col_hi, col_lo}) |-> $past(charge));

    // R3
    drive_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|{col_hi, col_lo}) && $past(|{col_hi, col_lo})) |-> $stable({col_hi, col_lo}));

    // R5
    tail_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(col_hi[NCOL-9]) && $past(enable)) |-> (charge && {col_hi, col_lo} == '0));

    // R7
    ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready && enable) |=> (!evt_valid || evt_index > $past(evt_index)));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready && enable) |=> (evt_valid && $stable(evt_index) && $stable(evt_state)));

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!evt_valid && !charge && {col_hi, col_lo} == '0));

    // R11
    press_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready && enable && evt_state) |=> keydown);
endmodule

// File: tb/kbd_matrix_scanner_tb.sv
`timescale 1ns/1ps
module kbd_matrix_scanner_tb;
    localparam int NC = 12;
    localparam int NR = 7;
    localparam int NK = NC * NR;
    localparam int HZ = 200_000_000;
    localparam int S  = (HZ / 1000) * 50 / 1_000_000;    // 50 ns settle -> 10 cycles
    localparam int P  = (HZ / 1000) * 2500 / 1_000_000;  // 2500 ns period -> 500 cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic evt_ready = 1'b1;
    logic [NR-1:0] row_in;
    logic [7:0] col_lo;
    logic [NC-9:0] col_hi;
    logic charge, evt_valid, evt_state, keydown;
    logic [6:0] evt_index;

    always #2.5 clk = ~clk;

    kbd_matrix_scanner #(.NCOL(NC), .NROW(NR), .CLK_HZ(HZ), .SETTLE_NS(50), .PERIOD_NS(2500)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .col_lo(col_lo), .col_hi(col_hi),
        .charge(charge), .row_in(row_in), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_index(evt_index), .evt_state(evt_state), .keydown(keydown)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    bit keys [NK];
    bit rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    // key matrix: a driven column shows its closed keys on the rows
    always_comb begin
        row_in = '0;
        for (int c = 0; c < NC; c++)
            if ({col_hi, col_lo}[c])
                for (int r = 0; r < NR; r++)
                    if (keys[r + c * NR]) row_in[r] = 1'b1;
    end

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        evt_ready = rdy_mode ? (lfsr[0] & lfsr[5]) : 1'b1;
    end

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // behavioural time model: scan time t, emit cursor, period countdown
    bit m_active, m_emit, m_kd, pz, ch;
    int m_t, m_idx, m_per;
    bit m_cur [NK];
    bit m_prev [NK];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0; m_emit = 0; m_kd = 0; m_t = 0; m_idx = 0; m_per = 0;
            for (int k = 0; k < NK; k++) begin m_cur[k] = 0; m_prev[k] = 0; end
        end else begin
            pz = (m_per == 0);
            if (m_per > 0) m_per = m_per - 1;
            if (!m_active && !m_emit) begin
                if (enable && pz) begin
                    m_active = 1; m_t = 0; m_per = P - 1; m_kd = 0;
                end
            end else if (!enable) begin
                m_active = 0; m_emit = 0;
            end else if (m_active) begin
                if (m_t < 2 * S * NC && (m_t % (2 * S)) == 2 * S - 1)
                    for (int r = 0; r < NR; r++) m_cur[r + NR * (m_t / (2 * S))] = row_in[r];
                if (m_t == 2 * S * NC + S - 1) begin
                    m_active = 0; m_emit = 1; m_idx = 0;
                end else m_t++;
            end else begin
                ch = (m_cur[m_idx] != m_prev[m_idx]);
                if (ch && evt_ready) begin
                    m_prev[m_idx] = m_cur[m_idx];
                    if (m_cur[m_idx]) m_kd = 1;
                end
                if (!ch || evt_ready) begin
                    if (m_idx == NK - 1) m_emit = 0; else m_idx++;
                end
            end
        end
    end

    // per-cycle comparison, event log, start and pulse bookkeeping
    int ev_q[$];
    int start_q[$];
    int run_len = 0, first_pulse = -1;
    logic prev_charge = 0;
    logic [NC-1:0] prev_cols = '0;

    always @(negedge clk) begin
        int ec, ech, sub;
        string tag;
        if (rst_n && !done) begin
            ec = 0; ech = 0; tag = "R10";
            if (m_active && m_t < 2 * S * NC) begin
                sub = m_t % (2 * S);
                ech = (sub < S);
                ec = (sub >= S) ? (1 << (m_t / (2 * S))) : 0;
                tag = ech ? "R2" : "R3";
            end else if (m_active) begin
                ech = 1; tag = "R5";
            end else if (enable) tag = "R9";
            chk(tag, "columns", {col_hi, col_lo}, ec);
            chk(tag, "charge", charge, ech);
            chk("R6", "valid", evt_valid, m_emit && (m_cur[m_idx] != m_prev[m_idx]));
            if (m_emit && evt_valid) begin
                chk("R6", "index", evt_index, m_idx);
                chk("R6", "state", evt_state, m_cur[m_idx]);
            end
            chk("R11", "keydown", keydown, m_kd);
            if (evt_valid && evt_ready && enable) ev_q.push_back(evt_index * 2 + evt_state);
            if (charge && !prev_charge && prev_cols == '0) start_q.push_back(cyc);
            if (charge) run_len++;
            else begin
                if (run_len > 0 && first_pulse < 0) first_pulse = run_len;
                run_len = 0;
            end
            prev_charge = charge;
            prev_cols = {col_hi, col_lo};
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            report();
        end
    end

    task automatic wait_scan_done();
        do @(negedge clk); while (!(m_active || m_emit));
        do @(negedge clk); while (m_active || m_emit);
    endtask

    task automatic cmp_events(input string req, input int exp[$]);
        chk(req, "event count", ev_q.size(), exp.size());
        foreach (exp[i])
            if (i < ev_q.size()) chk(req, "event idx*2+state", ev_q[i], exp[i]);
    endtask

    task automatic set_key(input int k, input bit v);
        @(posedge clk); #1; keys[k] = v;
    endtask

    initial begin
        int quiet_charge;
        for (int k = 0; k < NK; k++) keys[k] = 0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset columns", {col_hi, col_lo}, 0);
        chk("R1", "reset charge", charge, 0);
        chk("R1", "reset valid", evt_valid, 0);
        chk("R1", "reset keydown", keydown, 0);

        // R10 disabled: no scan activity
        quiet_charge = 0;
        repeat (600) begin @(negedge clk); if (charge || {col_hi, col_lo} != 0) quiet_charge++; end
        chk("R10", "activity while disabled", quiet_charge, 0);

        @(posedge clk); #1 enable = 1;
        wait_scan_done();
        chk("R1", "events with no key down", ev_q.size(), 0);
        chk("R12", "settle pulse length", first_pulse, S);
        wait_scan_done();
        chk("R9", "starts seen", start_q.size() >= 2, 1);
        if (start_q.size() >= 2) chk("R9", "start spacing", start_q[1] - start_q[0], P);

        // R4 R6 R7 presses at boundary keys
        ev_q.delete();
        set_key(0, 1); set_key(3, 1); set_key(10, 1); set_key(50, 1); set_key(83, 1);
        wait_scan_done();
        cmp_events("R4", '{1, 7, 21, 101, 167});
        chk("R7", "last event is key 83", ev_q.size() > 0 ? ev_q[$] : -1, 167);
        chk("R11", "keydown after presses", keydown, 1);

        // R6 unchanged scan
        ev_q.delete();
        wait_scan_done();
        chk("R6", "events on unchanged scan", ev_q.size(), 0);
        chk("R11", "keydown after quiet scan", keydown, 0);

        // R8 stalls
        ev_q.delete();
        rdy_mode = 1;
        set_key(10, 0); set_key(20, 1); set_key(41, 1);
        wait_scan_done();
        cmp_events("R8", '{20, 41, 83});
        rdy_mode = 0;

        // R11 releases only
        ev_q.delete();
        set_key(0, 0); set_key(3, 0);
        wait_scan_done();
        cmp_events("R6", '{0, 6});
        chk("R11", "keydown after releases only", keydown, 0);

        // R10 disable mid-scan, change kept for later
        ev_q.delete();
        set_key(5, 1);
        do @(negedge clk); while (!(m_active && m_t == 30));
        @(posedge clk); #1 enable = 0;
        @(posedge clk); @(negedge clk);
        chk("R10", "charge after disable", charge, 0);
        chk("R10", "columns after disable", {col_hi, col_lo}, 0);
        repeat (50) @(negedge clk);
        chk("R10", "events while disabled", ev_q.size(), 0);
        @(posedge clk); #1 enable = 1;
        wait_scan_done();
        cmp_events("R10", '{11});

        done = 1;
        report();
    end
endmodule